// File: doc/BRIEF.md
# SPI Slave with Semaphore-Owned Buffers

This block is an SPI slave that trades bytes with an external master through one small transmit buffer and one small receive buffer, both held inside the block. A two-state hardware semaphore settles who may touch those buffers. While the local CPU side owns it, the CPU fills the transmit buffer and reads the receive buffer, and any chip-select transaction from the master is ignored. While the SPI side owns it, the next transaction moves bytes out of and into the buffers, and the CPU is told of its end with an event pulse.

The CPU side gives ownership away with a release strobe and takes it back with an acquire strobe. Auto-acquire can make the end of a served transaction hand ownership back without any strobe. The serial inputs are brought into the system clock with two-flop synchronisers, and all SPI edges are found in that domain. Any of the four clock-polarity and clock-phase combinations can be chosen, and bits always move MSB first. When the transmit buffer runs dry, a filler byte is sent. When the receive buffer is full, bytes are dropped. Each case raises a sticky flag.

The engine FSM has the states ENG_IDLE, ENG_SERVE and ENG_IGNORE. ENG_IDLE goes to ENG_SERVE on a chip-select fall while the SPI side owns the semaphore, and to ENG_IGNORE on a fall while the CPU owns it. Either active state goes back to ENG_IDLE on a chip-select rise, and the exit from ENG_SERVE raises the end event. The semaphore FSM has the states SEM_CPU and SEM_SPI. A granted acquire moves it to SEM_CPU, and a granted release moves it to SEM_SPI. Grants are made only while the engine is idle and chip-select is high.

Top module: `spi_sem_slave`

## Requirements
- R1: After reset the CPU side owns the semaphore (sem_cpu_own=1). Both byte counts and both flags are 0. The configuration is mode 0, filler byte 0x00, ignore byte 0x00, auto-acquire on.
- R2: cfg_mode bit 1 is clock polarity (idle level of SCK) and bit 0 is clock phase. Phase 0 samples MOSI on the leading edge, and phase 1 samples on the trailing edge. MISO changes on the opposite edge. Bytes are MSB first.
- R3: In a served transaction, byte k on MISO is transmit buffer entry k, and received byte k is stored in receive buffer entry k. After the transaction, tx_done_cnt holds the number of whole bytes sent from the buffer, and rx_done_cnt holds the number of whole bytes stored. A partial final byte is not counted.
- R4: Once tx_limit bytes have been taken from the transmit buffer, each further byte on MISO is the configured filler byte. A whole filler byte sets flag_overread.
- R5: Whole bytes received after rx_limit bytes are stored are discarded, and each such byte sets flag_overflow. The buffer entries at and above rx_limit keep their contents.
- R6: Both flags are sticky. Each clears only on a pulse of its own clear input, and new transfers never clear them.
- R7: A transaction that starts while the CPU owns the semaphore drives the ignore byte on MISO for its whole length. It stores nothing, leaves both counts and both flags unchanged and raises no end event.
- R8: An acquire strobe gives ownership to the CPU (sem_cpu_own=1) and raises a one-cycle evt_acquired pulse.
- R9: A release strobe gives ownership to the SPI side (sem_cpu_own=0).
- R10: evt_end pulses for one cycle after chip-select rises at the end of a served transaction.
- R11: With auto-acquire on, the end of a served transaction returns ownership to the CPU and raises evt_acquired. With it off, ownership stays with the SPI side.
- R12: When acquire and release come in the same cycle, acquire wins. A strobe that arrives while a transaction is in progress is held, and ownership changes only after chip-select has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| acquire_req | input | 1 | CPU strobe: take ownership |
| release_req | input | 1 | CPU strobe: give ownership to SPI |
| sem_cpu_own | output | 1 | 1 while the CPU owns the semaphore |
| evt_end | output | 1 | Pulse at the end of a served transaction |
| evt_acquired | output | 1 | Pulse when ownership goes to the CPU |
| cfg_wr | input | 1 | Load the four cfg_*_in values |
| cfg_mode_in | input | 2 | SPI mode: bit 1 polarity, bit 0 phase |
| cfg_ovr_in | input | 8 | Filler byte sent after the transmit limit |
| cfg_def_in | input | 8 | Byte sent in ignored transactions |
| cfg_auto_in | input | 1 | Auto-acquire enable |
| tx_limit | input | CW | Maximum bytes taken from the transmit buffer |
| rx_limit | input | CW | Maximum bytes stored in the receive buffer |
| tx_wr_en | input | 1 | Transmit buffer write enable |
| tx_wr_addr | input | AW | Transmit buffer write address |
| tx_wr_data | input | 8 | Transmit buffer write data |
| rx_rd_addr | input | AW | Receive buffer read address |
| rx_rd_data | output | 8 | Receive buffer read data (combinational) |
| tx_done_cnt | output | CW | Bytes sent from the buffer in the last served transaction |
| rx_done_cnt | output | CW | Bytes stored in the last served transaction |
| flag_overflow | output | 1 | Sticky receive-limit overflow flag |
| flag_overread | output | 1 | Sticky transmit-limit overread flag |
| clr_overflow | input | 1 | Clear flag_overflow |
| clr_overread | input | 1 | Clear flag_overread |

## Verification
The properties rest on the SCK half-period being several system clocks long, so that every synchronised edge is seen and MISO settles before the master samples it. The bench therefore holds each SCK level for eight system clocks and waits eight clocks between chip-select fall and the first edge. The properties also take the limits to be steady while a transaction runs, and to be no larger than the buffer depth. The bench changes the limits, the configuration and the buffer contents only while chip-select is high. CPU strobes are single-cycle pulses driven on the falling clock edge.

// File: rtl/spis_pkg.sv
package spis_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_SERVE  = 2'd1,
        ENG_IGNORE = 2'd2
    } eng_state_t;

    typedef enum logic {
        SEM_CPU = 1'b0,
        SEM_SPI = 1'b1
    } sem_state_t;

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] ovr_byte;
        logic [7:0] def_byte;
        logic       auto_acq;
    } spis_cfg_t;

    localparam spis_cfg_t CFG_RESET = '{mode: 2'd0, ovr_byte: 8'h00,
                                        def_byte: 8'h00, auto_acq: 1'b1};

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= din[i];
                stab_q <= meta_q;
            end
        end
        assign dout[i] = stab_q;
    end
endmodule

// File: rtl/spis_bytebuf.sv
module spis_bytebuf #(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spis_sem_fsm.sv
module spis_sem_fsm
    import spis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acquire_req,
    input  logic release_req,
    input  logic auto_en,
    input  logic end_pulse,
    input  logic busy,
    output logic cpu_owns,
    output logic acquired_evt
);
    sem_state_t state, state_nx;
    logic acq_pend, rel_pend;
    logic want_acq, want_rel;

    assign want_acq = acquire_req | acq_pend | (auto_en & end_pulse);
    assign want_rel = release_req | rel_pend;

    always_comb begin
        state_nx = state;
        unique case (state)
            SEM_CPU: if (!busy && !want_acq && want_rel) state_nx = SEM_SPI;
            SEM_SPI: if (!busy && want_acq)              state_nx = SEM_CPU;
            default: state_nx = SEM_CPU;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEM_CPU;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acquired_evt <= 1'b0;
            acq_pend     <= 1'b0;
            rel_pend     <= 1'b0;
        end else begin
            acquired_evt <= !busy && want_acq;
            acq_pend     <= busy && want_acq;
            rel_pend     <= busy && want_rel;
        end
    end

    assign cpu_owns = (state == SEM_CPU);
endmodule

// File: rtl/spis_engine.sv
module spis_engine
    import spis_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          cs_act,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          mosi,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          spi_owns,
    input  logic [7:0]    ovr_byte,
    input  logic [7:0]    def_byte,
    input  logic [CW-1:0] tx_limit,
    input  logic [CW-1:0] rx_limit,
    output logic [AW-1:0] tx_raddr,
    input  logic [7:0]    tx_rdata,
    output logic          rx_we,
    output logic [AW-1:0] rx_waddr,
    output logic [7:0]    rx_wdata,
    output logic          miso,
    output logic          end_pulse,
    output logic          busy,
    output logic          ovf_set,
    output logic          ovr_set,
    output logic [CW-1:0] tx_count,
    output logic [CW-1:0] rx_count
);
    localparam logic [CW-1:0] ONE = CW'(1);

    eng_state_t state, state_nx;
    logic [2:0]    bit_cnt;
    logic [6:0]    rx_sh;
    logic [7:0]    tx_sh;
    logic          from_buf;
    logic [CW-1:0] tx_idx, rd_idx;
    logic          active, sample_edge, drive_edge, byte_done;
    logic          fetch_serve, have_data, room;
    logic [7:0]    fetch_byte;

    assign active      = (state != ENG_IDLE);
    assign sample_edge = (cpol ^ cpha) ? sck_fall : sck_rise;
    assign drive_edge  = (cpol ^ cpha) ? sck_rise : sck_fall;
    assign byte_done   = active && sample_edge && (bit_cnt == 3'd7);
    assign fetch_serve = (state == ENG_IDLE) ? spi_owns : (state == ENG_SERVE);
    assign rd_idx      = (state == ENG_IDLE) ? '0 : tx_idx;
    assign have_data   = fetch_serve && (rd_idx < tx_limit);
    assign fetch_byte  = !fetch_serve ? def_byte : (have_data ? tx_rdata : ovr_byte);
    assign tx_raddr    = rd_idx[AW-1:0];
    assign room        = (rx_count < rx_limit);

    always_comb begin
        state_nx = state;
        unique case (state)
            ENG_IDLE:   if (cs_fall) state_nx = spi_owns ? ENG_SERVE : ENG_IGNORE;
            ENG_SERVE:  if (cs_rise) state_nx = ENG_IDLE;
            ENG_IGNORE: if (cs_rise) state_nx = ENG_IDLE;
            default:    state_nx = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            from_buf <= 1'b0;
            tx_idx   <= '0;
            tx_count <= '0;
            rx_count <= '0;
        end else if (state == ENG_IDLE) begin
            if (cs_fall) begin
                bit_cnt  <= '0;
                tx_sh    <= fetch_byte;
                from_buf <= have_data;
                tx_idx   <= (!cpha && have_data) ? ONE : '0;
                if (spi_owns) begin
                    tx_count <= '0;
                    rx_count <= '0;
                end
            end
        end else begin
            if (sample_edge) begin
                rx_sh   <= {rx_sh[5:0], mosi};
                bit_cnt <= bit_cnt + 3'd1;
                if (byte_done && state == ENG_SERVE) begin
                    if (room)     rx_count <= rx_count + ONE;
                    if (from_buf) tx_count <= tx_count + ONE;
                end
            end
            if (drive_edge) begin
                if (bit_cnt == 3'd0) begin
                    tx_sh    <= fetch_byte;
                    from_buf <= have_data;
                    if (have_data) tx_idx <= tx_idx + ONE;
                end else begin
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    assign rx_we     = byte_done && (state == ENG_SERVE) && room;
    assign rx_waddr  = rx_count[AW-1:0];
    assign rx_wdata  = {rx_sh, mosi};
    assign ovf_set   = byte_done && (state == ENG_SERVE) && !room;
    assign ovr_set   = byte_done && (state == ENG_SERVE) && !from_buf;
    assign end_pulse = (state == ENG_SERVE) && cs_rise;
    assign busy      = active || cs_act;
    assign miso      = tx_sh[7];
endmodule

// File: rtl/spi_sem_slave.sv
module spi_sem_slave
    import spis_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_cs_n,
    input  logic          spi_mosi,
    output logic          spi_miso,
    input  logic          acquire_req,
    input  logic          release_req,
    output logic          sem_cpu_own,
    output logic          evt_end,
    output logic          evt_acquired,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_mode_in,
    input  logic [7:0]    cfg_ovr_in,
    input  logic [7:0]    cfg_def_in,
    input  logic          cfg_auto_in,
    input  logic [CW-1:0] tx_limit,
    input  logic [CW-1:0] rx_limit,
    input  logic          tx_wr_en,
    input  logic [AW-1:0] tx_wr_addr,
    input  logic [7:0]    tx_wr_data,
    input  logic [AW-1:0] rx_rd_addr,
    output logic [7:0]    rx_rd_data,
    output logic [CW-1:0] tx_done_cnt,
    output logic [CW-1:0] rx_done_cnt,
    output logic          flag_overflow,
    output logic          flag_overread,
    input  logic          clr_overflow,
    input  logic          clr_overread
);
    spis_cfg_t     cfg_q;
    logic [2:0]    sync_lvl;
    logic          sck_q, cs_q;
    logic          sck_rise, sck_fall, cs_fall, cs_rise;
    logic [AW-1:0] tx_raddr, rx_waddr;
    logic [7:0]    tx_rdata, rx_wdata;
    logic          rx_we, eng_busy, ovf_set, ovr_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= CFG_RESET;
        else if (cfg_wr) cfg_q <= '{mode: cfg_mode_in, ovr_byte: cfg_ovr_in,
                                    def_byte: cfg_def_in, auto_acq: cfg_auto_in};
    end

    spis_sync #(.N(3), .RST_VAL(3'b010)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .din({spi_mosi, spi_cs_n, spi_sck}), .dout(sync_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sync_lvl[0];
            cs_q  <= sync_lvl[1];
        end
    end

    assign sck_rise = sync_lvl[0] & ~sck_q;
    assign sck_fall = ~sync_lvl[0] & sck_q;
    assign cs_fall  = ~sync_lvl[1] & cs_q;
    assign cs_rise  = sync_lvl[1] & ~cs_q;

    spis_bytebuf #(.DEPTH(DEPTH)) txbuf_i (
        .clk(clk), .we(tx_wr_en), .waddr(tx_wr_addr), .wdata(tx_wr_data),
        .raddr(tx_raddr), .rdata(tx_rdata)
    );

    spis_bytebuf #(.DEPTH(DEPTH)) rxbuf_i (
        .clk(clk), .we(rx_we), .waddr(rx_waddr), .wdata(rx_wdata),
        .raddr(rx_rd_addr), .rdata(rx_rd_data)
    );

    spis_engine #(.DEPTH(DEPTH)) eng_i (
        .clk(clk), .rst_n(rst_n),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_act(~sync_lvl[1]),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi(sync_lvl[2]),
        .cpol(cfg_q.mode[1]), .cpha(cfg_q.mode[0]), .spi_owns(~sem_cpu_own),
        .ovr_byte(cfg_q.ovr_byte), .def_byte(cfg_q.def_byte),
        .tx_limit(tx_limit), .rx_limit(rx_limit),
        .tx_raddr(tx_raddr), .tx_rdata(tx_rdata),
        .rx_we(rx_we), .rx_waddr(rx_waddr), .rx_wdata(rx_wdata),
        .miso(spi_miso), .end_pulse(evt_end), .busy(eng_busy),
        .ovf_set(ovf_set), .ovr_set(ovr_set),
        .tx_count(tx_done_cnt), .rx_count(rx_done_cnt)
    );

    spis_sem_fsm sem_i (
        .clk(clk), .rst_n(rst_n),
        .acquire_req(acquire_req), .release_req(release_req),
        .auto_en(cfg_q.auto_acq), .end_pulse(evt_end), .busy(eng_busy),
        .cpu_owns(sem_cpu_own), .acquired_evt(evt_acquired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_overflow <= 1'b0;
            flag_overread <= 1'b0;
        end else begin
            if (ovf_set)           flag_overflow <= 1'b1;
            else if (clr_overflow) flag_overflow <= 1'b0;
            if (ovr_set)           flag_overread <= 1'b1;
            else if (clr_overread) flag_overread <= 1'b0;
        end
    end
endmodule

// File: rtl/spis_sem_chk.sv
module spis_sem_chk #(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sem_cpu_own,
    input logic          evt_end,
    input logic          evt_acquired,
    input logic          busy,
    input logic          rx_we,
    input logic [AW-1:0] rx_waddr,
    input logic [CW-1:0] rx_limit
);
    // R8
    acq_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_acquired |-> sem_cpu_own);

    // R7
    ignore_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> !sem_cpu_own);

    // R10
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_end |=> !evt_end);

    // R10
    end_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_end |-> !sem_cpu_own);

    // R12
    hold_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(sem_cpu_own));

    // R5
    rx_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> ({1'b0, rx_waddr} < rx_limit));
endmodule

bind spi_sem_slave spis_sem_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .sem_cpu_own(sem_cpu_own), .evt_end(evt_end),
    .evt_acquired(evt_acquired), .busy(eng_busy), .rx_we(rx_we),
    .rx_waddr(rx_waddr), .rx_limit(rx_limit)
);

// File: tb/spi_sem_slave_tb_top.sv
`timescale 1ns/1ps
module spi_sem_slave_tb_top;
    localparam int DEPTH = 8;
    localparam int AW = 3;
    localparam int CW = 4;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, spi_miso;
    logic acquire_req = 1'b0, release_req = 1'b0;
    logic sem_cpu_own, evt_end, evt_acquired;
    logic cfg_wr = 1'b0, cfg_auto_in = 1'b1;
    logic [1:0] cfg_mode_in = '0;
    logic [7:0] cfg_ovr_in = '0, cfg_def_in = '0;
    logic [CW-1:0] tx_limit = '0, rx_limit = '0;
    logic tx_wr_en = 1'b0;
    logic [AW-1:0] tx_wr_addr = '0, rx_rd_addr = '0;
    logic [7:0] tx_wr_data = '0, rx_rd_data;
    logic [CW-1:0] tx_done_cnt, rx_done_cnt;
    logic flag_overflow, flag_overread;
    logic clr_overflow = 1'b0, clr_overread = 1'b0;

    int n_chk = 0, n_fail = 0, end_cnt = 0, acq_cnt = 0, cyc = 0;
    bit done = 0;
    logic [7:0] mosi_q [16];
    logic [7:0] miso_q [16];

    always #4 clk = ~clk;

    spi_sem_slave #(.DEPTH(DEPTH)) dut_i (.*);

    always @(posedge clk) begin
        if (rst_n) begin
            if (evt_end) end_cnt++;
            if (evt_acquired) acq_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: run hung actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [7:0] o, input logic [7:0] d, input logic a);
        @(negedge clk);
        cfg_mode_in = m; cfg_ovr_in = o; cfg_def_in = d; cfg_auto_in = a; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wr_tx(input int a, input logic [7:0] d);
        @(negedge clk);
        tx_wr_en = 1'b1; tx_wr_addr = AW'(a); tx_wr_data = d;
        @(negedge clk);
        tx_wr_en = 1'b0;
    endtask

    task automatic rd_rx(input int a, output logic [7:0] d);
        @(negedge clk);
        rx_rd_addr = AW'(a);
        #1 d = rx_rd_data;
    endtask

    task automatic pulse_acq();
        @(negedge clk); acquire_req = 1'b1;
        @(negedge clk); acquire_req = 1'b0;
        waitc(2);
    endtask

    task automatic pulse_rel();
        @(negedge clk); release_req = 1'b1;
        @(negedge clk); release_req = 1'b0;
        waitc(2);
    endtask

    task automatic spi_xfer(input logic [1:0] md, input int nb);
        logic cpol, cpha;
        cpol = md[1]; cpha = md[0];
        spi_sck = cpol;
        waitc(H);
        spi_cs_n = 1'b0;
        waitc(H);
        for (int b = 0; b < nb; b++) begin
            for (int i = 7; i >= 0; i--) begin
                if (!cpha) begin
                    spi_mosi = mosi_q[b][i];
                    waitc(H);
                    miso_q[b][i] = spi_miso;
                    spi_sck = ~cpol;
                    waitc(H);
                    spi_sck = cpol;
                end else begin
                    spi_sck = ~cpol;
                    spi_mosi = mosi_q[b][i];
                    waitc(H);
                    miso_q[b][i] = spi_miso;
                    spi_sck = cpol;
                    waitc(H);
                end
            end
        end
        waitc(H);
        spi_cs_n = 1'b1;
        waitc(2 * H);
    endtask

    task automatic t_reset();
        chk("R1 owner after reset", sem_cpu_own, 1);
        chk("R1 tx count after reset", tx_done_cnt, 0);
        chk("R1 rx count after reset", rx_done_cnt, 0);
        chk("R1 overflow after reset", flag_overflow, 0);
        chk("R1 overread after reset", flag_overread, 0);
        chk("R1 no events after reset", end_cnt + acq_cnt, 0);
    endtask

    task automatic t_default_ignore();
        mosi_q[0] = 8'h9E;
        spi_xfer(2'd0, 1);
        chk("R1 R7 reset ignore byte", miso_q[0], 8'h00);
        chk("R7 no end event", end_cnt, 0);
        chk("R7 rx count unchanged", rx_done_cnt, 0);
    endtask

    task automatic t_served_mode0();
        logic [7:0] d;
        logic [7:0] tx [3];
        tx = '{8'hA5, 8'h3C, 8'h81};
        for (int i = 0; i < 3; i++) wr_tx(i, tx[i]);
        tx_limit = 4'd3; rx_limit = 4'd3;
        pulse_rel();
        chk("R9 release", sem_cpu_own, 0);
        mosi_q[0] = 8'h11; mosi_q[1] = 8'h22; mosi_q[2] = 8'h33;
        spi_xfer(2'd0, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R3 R2 mode0 miso", miso_q[i], tx[i]);
            rd_rx(i, d);
            chk("R3 mode0 rx store", d, mosi_q[i]);
        end
        chk("R3 tx count", tx_done_cnt, 3);
        chk("R3 rx count", rx_done_cnt, 3);
        chk("R4 no overread", flag_overread, 0);
        chk("R5 no overflow", flag_overflow, 0);
        chk("R10 one end event", end_cnt, 1);
        chk("R11 auto acquire owner", sem_cpu_own, 1);
        chk("R11 auto acquire event", acq_cnt, 1);
    endtask

    task automatic t_modes();
        logic [7:0] d;
        for (int m = 1; m < 4; m++) begin
            set_cfg(2'(m), 8'h00, 8'h00, 1'b1);
            wr_tx(0, 8'h6B + 8'(m));
            wr_tx(1, 8'hD2 ^ 8'(m));
            tx_limit = 4'd2; rx_limit = 4'd2;
            pulse_rel();
            mosi_q[0] = 8'h4F + 8'(m); mosi_q[1] = 8'hB1 ^ 8'(m);
            spi_xfer(2'(m), 2);
            chk("R2 mode miso byte0", miso_q[0], 8'h6B + 8'(m));
            chk("R2 mode miso byte1", miso_q[1], 8'hD2 ^ 8'(m));
            rd_rx(0, d); chk("R2 mode rx byte0", d, mosi_q[0]);
            rd_rx(1, d); chk("R2 mode rx byte1", d, mosi_q[1]);
            chk("R3 mode counts", {tx_done_cnt, rx_done_cnt}, {4'd2, 4'd2});
        end
    endtask

    task automatic t_overread();
        set_cfg(2'd0, 8'h5A, 8'h00, 1'b1);
        wr_tx(0, 8'hE7);
        tx_limit = 4'd1; rx_limit = 4'd3;
        pulse_rel();
        mosi_q[0] = 8'h0F; mosi_q[1] = 8'h1E; mosi_q[2] = 8'h2D;
        spi_xfer(2'd0, 3);
        chk("R4 buffer byte", miso_q[0], 8'hE7);
        chk("R4 filler byte 1", miso_q[1], 8'h5A);
        chk("R4 filler byte 2", miso_q[2], 8'h5A);
        chk("R4 tx count at limit", tx_done_cnt, 1);
        chk("R4 overread flag", flag_overread, 1);
        chk("R5 overflow stays 0", flag_overflow, 0);
        waitc(20);
        chk("R6 overread sticky", flag_overread, 1);
        @(negedge clk); clr_overread = 1'b1;
        @(negedge clk); clr_overread = 1'b0;
        chk("R6 overread cleared", flag_overread, 0);
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        for (int i = 0; i < 3; i++) wr_tx(i, 8'h40 + 8'(i));
        tx_limit = 4'd3; rx_limit = 4'd2;
        pulse_rel();
        mosi_q[0] = 8'h71; mosi_q[1] = 8'h72; mosi_q[2] = 8'h73;
        spi_xfer(2'd0, 3);
        rd_rx(0, d); chk("R5 stored byte0", d, 8'h71);
        rd_rx(1, d); chk("R5 stored byte1", d, 8'h72);
        rd_rx(2, d); chk("R5 entry above limit kept", d, 8'h2D);
        chk("R5 rx count at limit", rx_done_cnt, 2);
        chk("R5 overflow flag", flag_overflow, 1);
        chk("R6 overread not set again", flag_overread, 0);
        @(negedge clk); clr_overflow = 1'b1;
        @(negedge clk); clr_overflow = 1'b0;
        chk("R6 overflow cleared", flag_overflow, 0);
    endtask

    task automatic t_ignore();
        logic [7:0] d;
        int e0;
        set_cfg(2'd0, 8'h5A, 8'hC3, 1'b1);
        rx_limit = 4'd1;
        e0 = end_cnt;
        mosi_q[0] = 8'h99; mosi_q[1] = 8'h98;
        spi_xfer(2'd0, 2);
        chk("R7 ignore byte 0", miso_q[0], 8'hC3);
        chk("R7 ignore byte 1", miso_q[1], 8'hC3);
        rd_rx(0, d); chk("R7 rx entry0 untouched", d, 8'h71);
        rd_rx(1, d); chk("R7 rx entry1 untouched", d, 8'h72);
        chk("R7 counts untouched", {tx_done_cnt, rx_done_cnt}, {4'd3, 4'd2});
        chk("R7 flags untouched", {flag_overflow, flag_overread}, 2'b00);
        chk("R7 no end event", end_cnt, e0);
    endtask

    task automatic t_no_auto();
        int a0, e0;
        set_cfg(2'd0, 8'h00, 8'h00, 1'b0);
        wr_tx(0, 8'h5C);
        tx_limit = 4'd1; rx_limit = 4'd1;
        pulse_rel();
        a0 = acq_cnt; e0 = end_cnt;
        mosi_q[0] = 8'h3A;
        spi_xfer(2'd0, 1);
        chk("R3 served byte", miso_q[0], 8'h5C);
        chk("R10 end event", end_cnt, e0 + 1);
        chk("R11 no auto acquire", sem_cpu_own, 0);
        chk("R11 no acquired event", acq_cnt, a0);
        pulse_acq();
        chk("R8 acquire owner", sem_cpu_own, 1);
        chk("R8 acquired event", acq_cnt, a0 + 1);
    endtask

    task automatic t_priority();
        int a0;
        pulse_rel();
        chk("R9 release", sem_cpu_own, 0);
        a0 = acq_cnt;
        @(negedge clk); acquire_req = 1'b1; release_req = 1'b1;
        @(negedge clk); acquire_req = 1'b0; release_req = 1'b0;
        waitc(2);
        chk("R12 acquire wins", sem_cpu_own, 1);
        chk("R12 acquire event", acq_cnt, a0 + 1);
        pulse_rel();
        mosi_q[0] = 8'h12;
        fork
            spi_xfer(2'd0, 1);
            begin
                waitc(40);
                pulse_acq();
                waitc(5);
                chk("R12 held during transaction", sem_cpu_own, 0);
            end
        join
        waitc(4);
        chk("R12 applied after cs rise", sem_cpu_own, 1);
        chk("R12 held acquire event", acq_cnt, a0 + 2);
    endtask

    initial begin
        waitc(10);
        rst_n = 1'b1;
        waitc(4);
        t_reset();
        t_default_ignore();
        t_served_mode0();
        t_modes();
        t_overread();
        t_overflow();
        t_ignore();
        t_no_auto();
        t_priority();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule